// File: doc/BRIEF.md
# Accumulator Core with a Ten-Opcode Data Transfer Set

The block is a small accumulator datapath. It holds an 8-bit accumulator, one 8-bit general register and a registered 8-bit output port. On each clock edge it carries out the single instruction presented on a 4-bit opcode input. That instruction can load a value from the input bus, move data between the accumulator and the register, drive the output port, or do one arithmetic or logic step on the accumulator.

The block has no program memory, program counter or fetch stage. An outside sequencer or a test bench supplies the opcode stream directly, one opcode per cycle. The block has no flags and no carry. Opcode values outside the defined set do nothing.

The output port is the only view of the internal state. To read the accumulator or the register, issue the instruction that copies it to the output port.

Top module: `accum_core`

## Requirements
- R1: With `rst` high on a clock edge, the accumulator, the register and `dout` are all set to zero on that edge.
- R2: Opcodes 1 and 6 load the accumulator from `din`.
- R3: Opcode 2 copies the accumulator into the register.
- R4: Opcode 3 sets `dout` to the register, and opcode 4 sets `dout` to the accumulator. Each value is the one held before that edge.
- R5: Opcode 5 loads the register from `din`.
- R6: Opcode 7 replaces the accumulator with the accumulator plus the register, modulo 256. No carry is kept.
- R7: Opcode 8 replaces the accumulator with the bitwise OR of the accumulator and the register. Opcode 9 does the same with the bitwise AND.
- R8: Opcode 10 replaces the accumulator with its bitwise complement.
- R9: The register changes only under opcodes 2 and 5. The accumulator keeps its value under opcodes 2, 3, 4 and 5.
- R10: `dout` keeps its value on every edge whose opcode is neither 3 nor 4.
- R11: Opcode 0 and opcodes 11 to 15 leave the accumulator, the register and `dout` unchanged, whatever value `din` has.
- R12: The opcode run 5, 1, 7, 4 with operands x and y shows (x+y) mod 256 on `dout` after the fourth edge. That is three instructions after the register load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Instruction to execute on this edge |
| din | input | 8 | Input data bus |
| dout | output | 8 | Registered output port |

## Verification
The assertions assume that `op_code` and `din` are settled at every rising edge. They also assume that `rst` is held for at least two edges at start-up, so that every `$past` value in the properties comes from reset state. The bench holds reset for three cycles. It changes `op_code` and `din` only on the falling clock edge. It covers each defined opcode, several undefined codes and a long pseudo-random opcode stream.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int DW  = 8;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP     = 4'd0,
    OP_LDA_IMM = 4'd1,
    OP_R_FROM_A = 4'd2,
    OP_OUT_R   = 4'd3,
    OP_OUT_A   = 4'd4,
    OP_LDR_IN  = 4'd5,
    OP_LDA_IN  = 4'd6,
    OP_ADD     = 4'd7,
    OP_OR      = 4'd8,
    OP_AND     = 4'd9,
    OP_INV     = 4'd10
  } op_e;

  typedef enum logic [2:0] {
    ASEL_KEEP, ASEL_IN, ASEL_ADD, ASEL_OR, ASEL_AND, ASEL_INV
  } asel_e;

  typedef enum logic [1:0] {RSEL_KEEP, RSEL_ACC, RSEL_IN} rsel_e;
  typedef enum logic [1:0] {OSEL_KEEP, OSEL_REG, OSEL_ACC} osel_e;

  typedef struct packed {
    asel_e a_sel;
    rsel_e r_sel;
    osel_e o_sel;
  } ctrl_t;
endpackage

// File: rtl/accum_decode.sv
module accum_decode
  import accum_pkg::*;
#(
  parameter int OP_W = OPW
) (
  input  logic [OP_W-1:0] op_code,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '{a_sel: ASEL_KEEP, r_sel: RSEL_KEEP, o_sel: OSEL_KEEP};
    case (op_code)
      4'd1, 4'd6: ctrl.a_sel = ASEL_IN;
      4'd2:       ctrl.r_sel = RSEL_ACC;
      4'd3:       ctrl.o_sel = OSEL_REG;
      4'd4:       ctrl.o_sel = OSEL_ACC;
      4'd5:       ctrl.r_sel = RSEL_IN;
      4'd7:       ctrl.a_sel = ASEL_ADD;
      4'd8:       ctrl.a_sel = ASEL_OR;
      4'd9:       ctrl.a_sel = ASEL_AND;
      4'd10:      ctrl.a_sel = ASEL_INV;
      default:    ctrl = '{a_sel: ASEL_KEEP, r_sel: RSEL_KEEP, o_sel: OSEL_KEEP};
    endcase
  end
endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_pkg::*;
#(
  parameter int W = DW
) (
  input  asel_e        sel,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] rg,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc_next
);
  always_comb begin
    case (sel)
      ASEL_IN:  acc_next = din;
      ASEL_ADD: acc_next = acc + rg;
      ASEL_OR:  acc_next = acc | rg;
      ASEL_AND: acc_next = acc & rg;
      ASEL_INV: acc_next = ~acc;
      default:  acc_next = acc;
    endcase
  end
endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int W    = DW,
  parameter int OP_W = OPW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    din,
  output logic [W-1:0]    dout
);
  ctrl_t        ctrl;
  logic [W-1:0] acc_q, reg_q, acc_d;

  accum_decode #(.OP_W(OP_W)) u_dec (.op_code(op_code), .ctrl(ctrl));

  accum_alu #(.W(W)) u_alu (
    .sel(ctrl.a_sel), .acc(acc_q), .rg(reg_q), .din(din), .acc_next(acc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_q <= '0;
    else begin
      case (ctrl.r_sel)
        RSEL_ACC: reg_q <= acc_q;
        RSEL_IN:  reg_q <= din;
        default:  reg_q <= reg_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else begin
      case (ctrl.o_sel)
        OSEL_REG: dout <= reg_q;
        OSEL_ACC: dout <= acc_q;
        default:  dout <= dout;
      endcase
    end
  end

  // R9: register touched only by opcodes 2 and 5
  a_r9_reg_hold: assert property (@(posedge clk) disable iff (rst)
    !(op_code == 4'd2 || op_code == 4'd5) |=> $stable(reg_q));
  // R10: output port held unless opcode 3 or 4
  a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
    !(op_code == 4'd3 || op_code == 4'd4) |=> $stable(dout));
  // R4: opcode 4 shows the earlier accumulator
  a_r4_out_acc: assert property (@(posedge clk) disable iff (rst)
    op_code == 4'd4 |=> dout == $past(acc_q));
  // R6: wrapping addition
  a_r6_add_wrap: assert property (@(posedge clk) disable iff (rst)
    op_code == 4'd7 |=> acc_q == W'($past(acc_q) + $past(reg_q)));
  // R11: undefined codes change nothing
  a_r11_noop: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd0 || op_code > 4'd10) |=> ($stable(acc_q) && $stable(reg_q)));
endmodule

// File: tb/tb_accum_core.sv
module tb_accum_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_code = 4'd0;
  logic [7:0] din = 8'd0;
  logic [7:0] dout;

  int total = 0;
  int bad = 0;
  int ma = 0, mr = 0, mo = 0;

  always #2 clk = ~clk;

  accum_core dut (.clk(clk), .rst(rst), .op_code(op_code), .din(din), .dout(dout));

  task automatic check(input string tag, input int exp);
    total++;
    if (int'(dout) != exp) begin
      bad++;
      $display("FAIL %s: dout=%0h expected=%0h", tag, dout, exp);
    end
  endtask

  // drive one instruction, advance the reference model, compare after the edge
  task automatic step(input int op, input int d, input string tag);
    @(negedge clk);
    op_code = 4'(op);
    din = 8'(d);
    case (op)
      1, 6: ma = d & 255;
      2:    mr = ma;
      3:    mo = mr;
      4:    mo = ma;
      5:    mr = d & 255;
      7:    ma = (ma + mr) & 255;
      8:    ma = ma | mr;
      9:    ma = ma & mr;
      10:   ma = (~ma) & 255;
      default: ;
    endcase
    @(posedge clk);
    #1;
    check(tag, mo);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: dout=%0h expected=finish", dout);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out", 0);
    @(negedge clk);
    rst = 1'b0;
    step(4, 8'h5a, "R1 acc");
    step(3, 8'h5a, "R1 reg");
    // R12 sequence
    step(5, 8'h23, "R12");
    step(1, 8'h41, "R12");
    step(7, 8'h00, "R12");
    step(4, 8'h00, "R12 sum");
    // R6 wrap
    step(5, 8'hf0, "R5 load");
    step(3, 8'h00, "R5 show");
    step(6, 8'h20, "R2 op6");
    step(7, 8'h00, "R6");
    step(4, 8'h00, "R6 wrap");
    // R7 / R8
    step(1, 8'h3c, "R2 op1");
    step(8, 8'h00, "R7 or");
    step(4, 8'h00, "R7 or");
    step(9, 8'h00, "R7 and");
    step(4, 8'h00, "R7 and");
    step(10, 8'h00, "R8");
    step(4, 8'h00, "R8");
    // R3 / R9
    step(2, 8'hff, "R3");
    step(3, 8'h00, "R3");
    step(4, 8'h00, "R9");
    // R11 undefined codes with noisy din
    step(0, 8'hff, "R11");
    step(11, 8'h77, "R11");
    step(15, 8'h11, "R11");
    step(3, 8'h99, "R11 reg");
    step(4, 8'h99, "R11 acc");
    // R10 long mixed stream
    for (int i = 0; i < 400; i++) begin
      step(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)), "R10");
    end
    step(3, 0, "R9 final reg");
    step(4, 0, "R9 final acc");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule